// File: doc/BRIEF.md
# Eight-Bit Compare/Capture Timer

This block is an up-counter with a count enable, two compare channels and two external trigger inputs that freeze the running count into capture registers. Compare channel 0 always compares. Register 1 is dual-use: in compare mode it holds a value that software writes, and in capture mode it is loaded from trigger input 2. A compare match on either channel raises a one-cycle interrupt pulse. Each match also toggles a timer output whose polarity can be chosen. The counter can be cleared on a register-1 match. In capture mode it can also be cleared on any capture.

Each trigger input passes through a two-flop synchronizer and then an edge detector. The valid edge is chosen per input. Using both edges gives pulse-width measurement and using one edge gives period measurement. A sticky overflow flag records every wrap of the counter past its maximum value.

Top module: `tmr_cc_core`

## Requirements
- R1: After reset the count is 0. On each clock edge with `cnt_en`=1, and with no clear pending, the count increments by one. From 0xFF it wraps to 0x00.
- R2: While `cnt_en`=0 and no capture-clear occurs, the count holds. Setting `cnt_en` to 1 again resumes counting from the held value.
- R3: When register 1 is in compare mode (`r1_capmode`=0), `clr_on_m1`=1 and the count equals `r1_q` with `cnt_en`=1, the next count is 0, so the counter cycles 0..N. With `clr_on_m1`=0 the counter goes on past the match.
- R4: Channel k raises `irq_mk` for exactly one cycle, on the clock edge that ends a cycle in which `cnt_en`=1 and the count equals that channel's value. Channel 0 compares against `cmp0_val` and channel 1 against `r1_q`.
- R5: Each output has a state bit. A match on its channel toggles the state while `out_en[k]`=1, and `out_en[k]`=0 clears it. The pin equals `out_alv[k]` when the state is 1 and `~out_alv[k]` when it is 0. The reset state is 0, so the pin shows `~out_alv[k]`. Output 0 follows channel 0 and output 1 follows channel 1.
- R6: `ovf_flag` is set on the edge at which the count wraps from 0xFF by incrementing. It stays set until a cycle with `ovf_clr`=1 and no wrap.
- R7: Suppose `trig1` changes before clock edge k. A valid edge then loads `cap0_q` at edge k+2, with the count held between edges k+1 and k+2.
- R8: In capture mode, a valid edge on `trig2` loads `r1_q` with the same timing as R7. In compare mode, `trig2` is ignored and `r1_q` keeps the value written through `r1_we`/`r1_wdata`.
- R9: A capture register keeps its value until the next valid edge on its own trigger input.
- R10: The edge select for each input is 2 bits: 00 none, 01 rising, 10 falling, 11 both. A transition that is not selected captures nothing.
- R11: When `r1_capmode`=1 and `clr_on_cap`=1, a capture into either register also sets the count to 0 on the capture edge. With `r1_capmode`=0, no capture clears the count.
- R12: In capture mode, register 1 produces no compare match: `irq_m1` stays 0 and `clr_on_m1` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_en | input | 1 | Count enable |
| cmp0_val | input | 8 | Compare value for channel 0 |
| r1_we | input | 1 | Write strobe for register 1 |
| r1_wdata | input | 8 | Write data for register 1 |
| r1_capmode | input | 1 | 1 = register 1 captures from trig2, 0 = register 1 compares |
| clr_on_m1 | input | 1 | Clear the count on a register-1 match |
| clr_on_cap | input | 1 | Clear the count on a capture (capture mode only) |
| trig1 | input | 1 | Asynchronous trigger for cap0_q |
| trig2 | input | 1 | Asynchronous trigger for register 1 |
| trig1_edge | input | 2 | Edge select for trig1 |
| trig2_edge | input | 2 | Edge select for trig2 |
| out_en | input | 2 | Per-output enable |
| out_alv | input | 2 | Per-output active level |
| ovf_clr | input | 1 | Clear the overflow flag |
| count | output | 8 | Current count |
| cap0_q | output | 8 | Dedicated capture register |
| r1_q | output | 8 | Register 1 contents |
| irq_m0 | output | 1 | Channel 0 match pulse |
| irq_m1 | output | 1 | Channel 1 match pulse |
| ovf_flag | output | 1 | Sticky overflow flag |
| tout | output | 2 | Timer output pins |

## Verification
The assertions assume that the control inputs are synchronous to `clk`. The trigger inputs may be asynchronous. The assertions also assume that a trigger input is low when reset is released, so that no false edge is seen. The bench changes every input only on the falling clock edge and keeps both triggers low through every reset. Trigger pulses are held for at least three cycles, so each level is seen by the synchronizer before it changes again. Sweeps cover every compare value on channel 0 and every clear-on-match period on channel 1. Expected counts are computed from the cycle offsets given in the requirements.

// File: rtl/tmr_cc_pkg.sv
// Shared types for the compare/capture timer.
package tmr_cc_pkg;
    // Edge qualifier for a trigger input
    typedef enum logic [1:0] {
        EDGE_NONE = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_sel_e;
endpackage

// File: rtl/tmr_edge_det.sv
// Synchronizes an asynchronous trigger input through SYNC_STAGES flops and
// then flags the edges that the select input enables.
// Assumes: the input is low when reset is released.
module tmr_edge_det
    import tmr_cc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       din,
    input  logic [1:0] sel,
    output logic       ev
);
    logic [SYNC_STAGES:0] sh;
    logic                 lvl, prv;

    // Shift chain: synchronizer stages plus one history flop
    always_ff @(posedge clk) begin
        if (!rst_n) sh <= '0;
        else        sh <= {sh[SYNC_STAGES-1:0], din};
    end

    assign lvl = sh[SYNC_STAGES-1];
    assign prv = sh[SYNC_STAGES];

    // Qualify the detected transition with the selected edge
    always_comb begin
        unique case (edge_sel_e'(sel))
            EDGE_RISE: ev = lvl & ~prv;
            EDGE_FALL: ev = ~lvl & prv;
            EDGE_BOTH: ev = lvl ^ prv;
            default:   ev = 1'b0;
        endcase
    end

    AST_EDGE_NEEDS_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        ev |-> (lvl != prv)); // R10
endmodule

// File: rtl/tmr_out_ch.sv
// One timer output. A state bit toggles on each match pulse while the output
// is enabled and is cleared while it is disabled. The pin shows the state
// mapped through the active-level bit.
// Assumes: hit is a single-cycle event from the compare logic.
module tmr_out_ch (
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic oe,
    input  logic alv,
    output logic pin
);
    logic state;

    // Toggle on match while enabled, return to inactive when disabled
    always_ff @(posedge clk) begin
        if (!rst_n)   state <= 1'b0;
        else if (!oe) state <= 1'b0;
        else if (hit) state <= ~state;
    end

    assign pin = state ? alv : ~alv;

    AST_OUT_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (oe && hit) |=> (!oe || (alv != $past(alv)) || (pin != $past(pin)))); // R5
endmodule

// File: rtl/tmr_cc_core.sv
// Compare/capture timer core: up-counter, two compare channels (register 1
// dual-use), two synchronized capture triggers, clear options, sticky
// overflow flag and two timer outputs.
// Assumes: control inputs are synchronous to clk; triggers may be async.
module tmr_cc_core
    import tmr_cc_pkg::*;
#(
    parameter int W           = 8,
    parameter int SYNC_STAGES = 2,
    parameter int N_OUT       = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_en,
    input  logic [W-1:0]     cmp0_val,
    input  logic             r1_we,
    input  logic [W-1:0]     r1_wdata,
    input  logic             r1_capmode,
    input  logic             clr_on_m1,
    input  logic             clr_on_cap,
    input  logic             trig1,
    input  logic             trig2,
    input  logic [1:0]       trig1_edge,
    input  logic [1:0]       trig2_edge,
    input  logic [N_OUT-1:0] out_en,
    input  logic [N_OUT-1:0] out_alv,
    input  logic             ovf_clr,
    output logic [W-1:0]     count,
    output logic [W-1:0]     cap0_q,
    output logic [W-1:0]     r1_q,
    output logic             irq_m0,
    output logic             irq_m1,
    output logic             ovf_flag,
    output logic [N_OUT-1:0] tout
);
    localparam logic [W-1:0] CNT_MAX = '1;

    logic [W-1:0]     cnt, cap0, r1;
    logic             ev1, ev2, cap2_ev;
    logic             hit0, hit1, m_clr, cap_clr, wrap;
    logic             irq0_r, irq1_r, ovf_r;
    logic [N_OUT-1:0] hit_vec;

    // Trigger conditioning for both inputs
    tmr_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_det1 (
        .clk(clk), .rst_n(rst_n), .din(trig1), .sel(trig1_edge), .ev(ev1));
    tmr_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_det2 (
        .clk(clk), .rst_n(rst_n), .din(trig2), .sel(trig2_edge), .ev(ev2));

    // Event decode for this cycle
    always_comb begin
        cap2_ev = ev2 & r1_capmode;
        hit0    = cnt_en & (cnt == cmp0_val);
        hit1    = cnt_en & ~r1_capmode & (cnt == r1);
        cap_clr = r1_capmode & clr_on_cap & (ev1 | cap2_ev);
        m_clr   = clr_on_m1 & hit1;
        wrap    = cnt_en & (cnt == CNT_MAX) & ~cap_clr & ~m_clr;
    end

    // Counter: capture-clear, then match-clear, then increment
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt <= '0;
        else if (cap_clr) cnt <= '0;
        else if (m_clr)   cnt <= '0;
        else if (cnt_en)  cnt <= cnt + 1'b1;
    end

    // Sticky overflow: a wrap wins over a clear request in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n)       ovf_r <= 1'b0;
        else if (wrap)    ovf_r <= 1'b1;
        else if (ovf_clr) ovf_r <= 1'b0;
    end

    // Dedicated capture register
    always_ff @(posedge clk) begin
        if (!rst_n)   cap0 <= '0;
        else if (ev1) cap0 <= cnt;
    end

    // Dual-use register 1: a capture wins over a software write
    always_ff @(posedge clk) begin
        if (!rst_n)       r1 <= '0;
        else if (cap2_ev) r1 <= cnt;
        else if (r1_we)   r1 <= r1_wdata;
    end

    // One-cycle match pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq0_r <= 1'b0;
            irq1_r <= 1'b0;
        end else begin
            irq0_r <= hit0;
            irq1_r <= hit1;
        end
    end

    assign hit_vec = N_OUT'({hit1, hit0});

    // One output channel per match source
    for (genvar k = 0; k < N_OUT; k++) begin : g_out
        tmr_out_ch u_out (
            .clk(clk), .rst_n(rst_n), .hit(hit_vec[k]),
            .oe(out_en[k]), .alv(out_alv[k]), .pin(tout[k]));
    end

    assign count    = cnt;
    assign cap0_q   = cap0;
    assign r1_q     = r1;
    assign irq_m0   = irq0_r;
    assign irq_m1   = irq1_r;
    assign ovf_flag = ovf_r;

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && !cap_clr && !m_clr) |=> (cnt == W'($past(cnt) + 1'b1))); // R1
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_en && !cap_clr) |=> $stable(cnt)); // R2
    AST_CLR_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (hit1 && clr_on_m1) |=> (cnt == '0)); // R3
    AST_IRQ_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        irq_m0 |-> ($past(cnt) == $past(cmp0_val))); // R4
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !ovf_clr) |=> ovf_flag); // R6
    AST_CAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !ev1 |=> $stable(cap0_q)); // R9
    AST_CAP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        cap_clr |=> (count == '0)); // R11
    AST_R1_NO_CMP: assert property (@(posedge clk) disable iff (!rst_n)
        irq_m1 |-> !$past(r1_capmode)); // R12
endmodule

// File: tb/tmr_cc_core_test.sv
module tmr_cc_core_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cnt_en = 1'b0;
    logic [7:0] cmp0_val = 8'd0;
    logic       r1_we = 1'b0;
    logic [7:0] r1_wdata = 8'd0;
    logic       r1_capmode = 1'b0, clr_on_m1 = 1'b0, clr_on_cap = 1'b0;
    logic       trig1 = 1'b0, trig2 = 1'b0;
    logic [1:0] trig1_edge = 2'b00, trig2_edge = 2'b00;
    logic [1:0] out_en = 2'b00, out_alv = 2'b00;
    logic       ovf_clr = 1'b0;
    logic [7:0] count, cap0_q, r1_q;
    logic       irq_m0, irq_m1, ovf_flag;
    logic [1:0] tout;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    tmr_cc_core uut (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .cmp0_val(cmp0_val),
        .r1_we(r1_we), .r1_wdata(r1_wdata), .r1_capmode(r1_capmode),
        .clr_on_m1(clr_on_m1), .clr_on_cap(clr_on_cap),
        .trig1(trig1), .trig2(trig2), .trig1_edge(trig1_edge),
        .trig2_edge(trig2_edge), .out_en(out_en), .out_alv(out_alv),
        .ovf_clr(ovf_clr), .count(count), .cap0_q(cap0_q), .r1_q(r1_q),
        .irq_m0(irq_m0), .irq_m1(irq_m1), .ovf_flag(ovf_flag), .tout(tout));

    always #10 clk = ~clk;

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        cnt_en = 1'b0;
        rst_n = 1'b0;
        step(1);
        rst_n = 1'b1;
    endtask

    task automatic write_r1(input int v);
        r1_wdata = 8'(v);
        r1_we = 1'b1;
        step(1);
        r1_we = 1'b0;
    endtask

    initial begin
        #(20 * 190000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual 0 expected 1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int c0;
        step(3);
        rst_n = 1'b1;
        // Reset state (R1, R5)
        check("R1 reset count", count, 0);
        check("R6 reset ovf", ovf_flag, 0);
        check("R5 reset pins", tout, 3);

        // Counting, holding, resuming (R1, R2)
        cnt_en = 1'b1; step(10);
        check("R1 count", count, 10);
        cnt_en = 1'b0; step(5);
        check("R2 hold", count, 10);
        cnt_en = 1'b1; step(3);
        check("R2 resume", count, 13);
        // Wrap and overflow (R1, R6)
        step(243);
        check("R1 wrap", count, 0);
        check("R6 ovf set", ovf_flag, 1);
        step(5);
        check("R6 ovf sticky", ovf_flag, 1);
        ovf_clr = 1'b1; step(1); ovf_clr = 1'b0;
        check("R6 ovf cleared", ovf_flag, 0);

        // Disabled outputs hold inactive level (R5)
        out_en = 2'b00; out_alv = 2'b01; step(1);
        check("R5 disabled pins", tout, 2);

        // Sweep every channel-0 compare value (R4, R5)
        for (int v = 0; v < 256; v++) begin
            int pulses, seen, pinbad;
            do_reset();
            cmp0_val = 8'(v); out_en = 2'b01; out_alv = 2'b01;
            cnt_en = 1'b1;
            pulses = 0; seen = -1; pinbad = 0;
            for (int s = 1; s <= 256; s++) begin
                step(1);
                if (irq_m0) begin pulses++; seen = count; end
                if (tout[0] != ((s > v) ? 1'b1 : 1'b0)) pinbad++;
            end
            check("R4 ch0 pulse", pulses * 1000 + seen, 1000 + ((v + 1) % 256));
            check("R5 ch0 pin", pinbad, 0);
        end

        // Sweep clear-on-match periods on register 1 (R3, R4, R5)
        for (int n = 0; n < 256; n++) begin
            int pulses, bad;
            do_reset();
            write_r1(n);
            clr_on_m1 = 1'b1; out_en = 2'b10; out_alv = 2'b10;
            cnt_en = 1'b1;
            pulses = 0; bad = 0;
            for (int s = 1; s <= 2 * n + 2; s++) begin
                step(1);
                if (count > n) bad++;
                if (irq_m1) begin
                    pulses++;
                    if (count != 0) bad++;
                    if (tout[1] != ((pulses % 2) == 1)) bad++;
                end
            end
            check("R3 clear period", bad, 0);
            check("R4 ch1 pulses", pulses, 2);
        end

        // No clear on match: counter continues (R3)
        do_reset();
        clr_on_m1 = 1'b0; write_r1(5);
        cnt_en = 1'b1; step(6);
        check("R4 ch1 no-clear pulse", irq_m1, 1);
        step(1);
        check("R3 continues", count, 7);

        // Capture on trig1 with edge selections (R7, R9, R10)
        do_reset();
        write_r1(200);
        trig1_edge = 2'b01; cnt_en = 1'b1;
        step(4);
        c0 = count; trig1 = 1'b1; step(3);
        check("R7 capture rise", cap0_q, c0 + 2);
        trig1 = 1'b0; step(5);
        check("R10 fall ignored", cap0_q, c0 + 2);
        trig1_edge = 2'b11;
        c0 = count; trig1 = 1'b1; step(3);
        check("R10 both rise", cap0_q, c0 + 2);
        c0 = count; trig1 = 1'b0; step(3);
        check("R10 both fall", cap0_q, c0 + 2);
        trig1_edge = 2'b10;
        c0 = cap0_q; trig1 = 1'b1; step(3);
        check("R10 rise ignored", cap0_q, c0);
        c0 = count; trig1 = 1'b0; step(3);
        check("R10 fall capture", cap0_q, c0 + 2);
        trig1_edge = 2'b00;
        c0 = cap0_q; trig1 = 1'b1; step(3); trig1 = 1'b0; step(3);
        check("R9 none holds", cap0_q, c0);

        // trig2 in compare mode is ignored, in capture mode it loads r1 (R8)
        trig2_edge = 2'b01;
        trig2 = 1'b1; step(3); trig2 = 1'b0; step(3);
        check("R8 compare mode ignores trig2", r1_q, 200);
        r1_capmode = 1'b1;
        c0 = count; trig2 = 1'b1; step(3);
        check("R8 capture into r1", r1_q, c0 + 2);
        trig2 = 1'b0;

        // Capture mode: no match from register 1 (R12)
        begin
            int pulses = 0;
            clr_on_m1 = 1'b1;
            for (int s = 0; s < 260; s++) begin
                step(1);
                if (irq_m1) pulses++;
            end
            check("R12 no ch1 match", pulses, 0);
            check("R9 r1 held", r1_q, c0 + 2);
            clr_on_m1 = 1'b0;
        end

        // Clear on capture (R11)
        clr_on_cap = 1'b1; step(3);
        c0 = count; trig1_edge = 2'b01; trig1 = 1'b1; step(3);
        check("R11 clear via trig1 cap", cap0_q, c0 + 2);
        check("R11 clear via trig1 cnt", count, 0);
        trig1 = 1'b0; step(10);
        c0 = count; trig2 = 1'b1; step(3);
        check("R11 clear via trig2 cap", r1_q, c0 + 2);
        check("R11 clear via trig2 cnt", count, 0);
        trig2 = 1'b0; step(3);
        r1_capmode = 1'b0; step(10);
        c0 = count; trig1 = 1'b1; step(3);
        check("R11 compare mode no clear", count, c0 + 3);
        trig1 = 1'b0;

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule